// File: doc/BRIEF.md
# Shared Iterative Multiply/Divide Unit

This block performs integer multiplication and division on two WIDTH-bit operands (WIDTH defaults to 32), in signed or unsigned form. It runs one iteration per clock cycle. A single shift register pair and one (WIDTH+1)-bit adder/subtractor carry out both operations. A multiply adds one partial product and shifts in each cycle, and yields a product of 2×WIDTH bits. A divide runs the restoring long-division recurrence, one trial subtraction per cycle, and yields a WIDTH-bit quotient and a WIDTH-bit remainder.

The caller raises `start_i` for one cycle with the operation code and both operands. The unit then holds `busy_o` high while it works. It pulses `done_o` for one cycle when the result words and the divide-by-zero flag become valid. Signed operands are converted to magnitudes in a setup cycle. The unsigned recurrence runs on those magnitudes, and a final cycle restores the signs.

Top module: `muldiv_unit`

## Requirements
- R1: After a start is accepted, `busy_o` is high for exactly WIDTH+2 cycles (one setup cycle, WIDTH iteration cycles and one sign-fix cycle). A divide with a zero divisor is the exception: it stays busy for exactly 2 cycles and runs no iterations. `done_o` is high in the first cycle in which `busy_o` is low again.
- R2: A `start_i` pulse that arrives while `busy_o` is high is ignored. The running operation keeps its operands and its timing.
- R3: With `op_i` = 2'b00 (unsigned multiply), {`res_hi_o`,`res_lo_o`} equals the full 2×WIDTH-bit unsigned product of `a_i` and `b_i`.
- R4: With `op_i` = 2'b01 (signed multiply), {`res_hi_o`,`res_lo_o`} equals the 2×WIDTH-bit two's-complement product of the signed operands.
- R5: With `op_i` = 2'b10 (unsigned divide, nonzero divisor), `res_lo_o` is the quotient `a_i`/`b_i` and `res_hi_o` is the remainder. Together they satisfy a = b×q + r with r < b.
- R6: With `op_i` = 2'b11 (signed divide, nonzero divisor), the quotient rounds toward zero and is negative when the operand signs differ. The remainder takes the sign of the dividend. The most negative dividend divided by −1 wraps to a quotient equal to the most negative value, with a remainder of 0.
- R7: A divide (`op_i[1]`=1) with `b_i` = 0 sets `div_zero_o`, returns all ones in `res_lo_o` and returns the unmodified dividend in `res_hi_o`. Every other operation leaves `div_zero_o` clear.
- R8: `done_o` is a one-cycle pulse. The results and `div_zero_o` hold their values until the next operation completes. After reset, `busy_o`, `done_o`, both result words and `div_zero_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when not busy |
| op_i | input | 2 | Bit 1: divide (1) or multiply (0); bit 0: signed (1) or unsigned (0) |
| a_i | input | WIDTH | Multiplicand or dividend |
| b_i | input | WIDTH | Multiplier or divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse when the results are valid |
| res_hi_o | output | WIDTH | Product high word, or remainder |
| res_lo_o | output | WIDTH | Product low word, or quotient |
| div_zero_o | output | 1 | Last divide had a zero divisor |

## Verification
The hardest cases to reach are the sign corners of the shared datapath. These are the most negative dividend over −1, magnitudes that equal the sign bit, zero divisors in signed mode, and a start pulse that lands in the middle of an iteration run. The bench builds the unit at WIDTH=4 and sweeps every operand pair under all four operation codes. Every such corner is therefore hit deterministically. A start pulse with different operands is also injected partway through selected operations, to show that it is ignored.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_ITER  = 2'd2,
        ST_FIX   = 2'd3
    } mdu_state_e;

    localparam int OP_DIV_BIT    = 1;
    localparam int OP_SIGNED_BIT = 0;

endpackage

// File: rtl/muldiv_operand_prep.sv
module muldiv_operand_prep #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             is_signed_i,
    output logic [WIDTH-1:0] mag_a_o,
    output logic [WIDTH-1:0] mag_b_o,
    output logic             neg_a_o,
    output logic             neg_b_o
);
    always_comb begin
        neg_a_o = is_signed_i & a_i[WIDTH-1];
        neg_b_o = is_signed_i & b_i[WIDTH-1];
        mag_a_o = neg_a_o ? (~a_i + WIDTH'(1)) : a_i;
        mag_b_o = neg_b_o ? (~b_i + WIDTH'(1)) : b_i;
    end
endmodule

// File: rtl/muldiv_step.sv
module muldiv_step #(
    parameter int WIDTH = 32
) (
    input  logic             is_div_i,
    input  logic [WIDTH-1:0] hi_i,
    input  logic [WIDTH-1:0] lo_i,
    input  logic [WIDTH-1:0] dvs_i,
    output logic [WIDTH-1:0] hi_o,
    output logic [WIDTH-1:0] lo_o
);
    logic [WIDTH:0] opa;
    logic [WIDTH:0] opb;
    logic [WIDTH:0] sum;
    logic           cin;
    logic           qbit;

    // single shared adder: add partial product, or trial-subtract divisor
    always_comb begin
        if (is_div_i) begin
            opa = {hi_i, lo_i[WIDTH-1]};
            opb = ~{1'b0, dvs_i};
            cin = 1'b1;
        end else begin
            opa = {1'b0, hi_i};
            opb = lo_i[0] ? {1'b0, dvs_i} : '0;
            cin = 1'b0;
        end
        sum  = opa + opb + {{WIDTH{1'b0}}, cin};
        qbit = ~sum[WIDTH];
        if (is_div_i) begin
            // negative trial result: keep shifted remainder (restore)
            hi_o = qbit ? sum[WIDTH-1:0] : opa[WIDTH-1:0];
            lo_o = {lo_i[WIDTH-2:0], qbit};
        end else begin
            hi_o = sum[WIDTH:1];
            lo_o = {sum[0], lo_i[WIDTH-1:1]};
        end
    end
endmodule

// File: rtl/muldiv_sign_fix.sv
module muldiv_sign_fix #(
    parameter int WIDTH = 32
) (
    input  logic             is_div_i,
    input  logic             dz_i,
    input  logic             neg_p_i,
    input  logic             neg_r_i,
    input  logic [WIDTH-1:0] dividend_i,
    input  logic [WIDTH-1:0] hi_i,
    input  logic [WIDTH-1:0] lo_i,
    output logic [WIDTH-1:0] res_hi_o,
    output logic [WIDTH-1:0] res_lo_o
);
    logic [2*WIDTH-1:0] prod;

    always_comb begin
        prod = {hi_i, lo_i};
        if (neg_p_i) begin
            prod = ~prod + (2*WIDTH)'(1);
        end
        if (!is_div_i) begin
            res_hi_o = prod[2*WIDTH-1:WIDTH];
            res_lo_o = prod[WIDTH-1:0];
        end else if (dz_i) begin
            res_hi_o = dividend_i;
            res_lo_o = '1;
        end else begin
            res_lo_o = neg_p_i ? (~lo_i + WIDTH'(1)) : lo_i;
            res_hi_o = neg_r_i ? (~hi_i + WIDTH'(1)) : hi_i;
        end
    end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
    import muldiv_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [1:0]       op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [WIDTH-1:0] res_hi_o,
    output logic [WIDTH-1:0] res_lo_o,
    output logic             div_zero_o
);
    localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LAST_STEP = CW'(WIDTH - 1);

    typedef struct packed {
        mdu_state_e       state;
        logic [1:0]       op;
        logic [WIDTH-1:0] a;
        logic [WIDTH-1:0] b;
        logic [WIDTH-1:0] hi;
        logic [WIDTH-1:0] lo;
        logic [WIDTH-1:0] dvs;
        logic [CW-1:0]    cnt;
        logic             neg_p;
        logic             neg_r;
        logic             dz;
        logic             done;
        logic [WIDTH-1:0] res_hi;
        logic [WIDTH-1:0] res_lo;
        logic             dz_out;
    } regs_t;

    regs_t r_d;
    regs_t r_q;

    logic [WIDTH-1:0] mag_a;
    logic [WIDTH-1:0] mag_b;
    logic             neg_a;
    logic             neg_b;
    logic [WIDTH-1:0] step_hi;
    logic [WIDTH-1:0] step_lo;
    logic [WIDTH-1:0] fix_hi;
    logic [WIDTH-1:0] fix_lo;
    logic             is_div;

    assign is_div = r_q.op[OP_DIV_BIT];

    muldiv_operand_prep #(.WIDTH(WIDTH)) u_prep (
        .a_i         (r_q.a),
        .b_i         (r_q.b),
        .is_signed_i (r_q.op[OP_SIGNED_BIT]),
        .mag_a_o     (mag_a),
        .mag_b_o     (mag_b),
        .neg_a_o     (neg_a),
        .neg_b_o     (neg_b)
    );

    muldiv_step #(.WIDTH(WIDTH)) u_step (
        .is_div_i (is_div),
        .hi_i     (r_q.hi),
        .lo_i     (r_q.lo),
        .dvs_i    (r_q.dvs),
        .hi_o     (step_hi),
        .lo_o     (step_lo)
    );

    muldiv_sign_fix #(.WIDTH(WIDTH)) u_fix (
        .is_div_i   (is_div),
        .dz_i       (r_q.dz),
        .neg_p_i    (r_q.neg_p),
        .neg_r_i    (r_q.neg_r),
        .dividend_i (r_q.a),
        .hi_i       (r_q.hi),
        .lo_i       (r_q.lo),
        .res_hi_o   (fix_hi),
        .res_lo_o   (fix_lo)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.op    = op_i;
                    r_d.a     = a_i;
                    r_d.b     = b_i;
                    r_d.state = ST_SETUP;
                end
            end
            ST_SETUP: begin
                r_d.hi    = '0;
                r_d.lo    = mag_a;
                r_d.dvs   = mag_b;
                r_d.cnt   = '0;
                r_d.neg_p = neg_a ^ neg_b;
                r_d.neg_r = neg_a;
                r_d.dz    = is_div && (r_q.b == '0);
                r_d.state = (is_div && (r_q.b == '0)) ? ST_FIX : ST_ITER;
            end
            ST_ITER: begin
                r_d.hi  = step_hi;
                r_d.lo  = step_lo;
                r_d.cnt = r_q.cnt + CW'(1);
                if (r_q.cnt == LAST_STEP) begin
                    r_d.state = ST_FIX;
                end
            end
            ST_FIX: begin
                r_d.res_hi = fix_hi;
                r_d.res_lo = fix_lo;
                r_d.dz_out = r_q.dz;
                r_d.done   = 1'b1;
                r_d.state  = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o     = (r_q.state != ST_IDLE);
    assign done_o     = r_q.done;
    assign res_hi_o   = r_q.res_hi;
    assign res_lo_o   = r_q.res_lo;
    assign div_zero_o = r_q.dz_out;

endmodule

// File: rtl/muldiv_unit_chk.sv
module muldiv_unit_chk #(
    parameter int WIDTH = 32
) (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic busy_o,
    input logic done_o,
    input logic div_zero_o
);
    int busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt <= 0;
        end else if (busy_o) begin
            busy_cnt <= busy_cnt + 1;
        end else begin
            busy_cnt <= 0;
        end
    end

    a_r1_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> ((busy_cnt == WIDTH + 2) || (busy_cnt == 2 && div_zero_o)));

    a_r1_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    a_r2_start_accepted_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    a_r7_dz_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div_zero_o) |-> done_o);

endmodule

bind muldiv_unit muldiv_unit_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .div_zero_o (div_zero_o)
);

// File: tb/muldiv_unit_tb.sv
module muldiv_unit_tb;
    localparam int W    = 4;
    localparam int MASK = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [1:0]   op_i = 2'b00;
    logic [W-1:0] a_i = '0;
    logic [W-1:0] b_i = '0;
    logic         busy_o;
    logic         done_o;
    logic [W-1:0] res_hi_o;
    logic [W-1:0] res_lo_o;
    logic         div_zero_o;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    muldiv_unit #(.WIDTH(W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .op_i       (op_i),
        .a_i        (a_i),
        .b_i        (b_i),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .res_hi_o   (res_hi_o),
        .res_lo_o   (res_lo_o),
        .div_zero_o (div_zero_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] op, input logic [W-1:0] a,
                          input logic [W-1:0] b, input bit inject);
        int ua, ub, sa, sb, p, eh, el, ecyc, cyc;
        bit edz;
        string rq;
        ua = int'(a);
        ub = int'(b);
        sa = int'($signed(a));
        sb = int'($signed(b));
        edz = 1'b0;
        case (op)
            2'b00: begin p = ua * ub; eh = (p >> W) & MASK; el = p & MASK; rq = "R3"; end
            2'b01: begin p = sa * sb; eh = (p >> W) & MASK; el = p & MASK; rq = "R4"; end
            2'b10: begin
                rq = "R5";
                if (ub == 0) begin edz = 1'b1; el = MASK; eh = ua; rq = "R7"; end
                else begin el = ua / ub; eh = ua % ub; end
            end
            default: begin
                rq = "R6";
                if (ub == 0) begin edz = 1'b1; el = MASK; eh = ua; rq = "R7"; end
                else begin el = (sa / sb) & MASK; eh = (sa % sb) & MASK; end
            end
        endcase
        ecyc = edz ? 2 : W + 2;

        @(negedge clk);
        start_i = 1'b1; op_i = op; a_i = a; b_i = b;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 0;
        while (busy_o && cyc < 100) begin
            cyc++;
            if (done_o) chk(1'b0, "R8 done during busy", 1, 0);
            // R2: a start pulse with different operands mid-run
            start_i = inject && (cyc == 2);
            if (inject && cyc == 2) begin
                a_i = ~a; b_i = b + W'(1); op_i = ~op;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        chk(cyc == ecyc, inject ? "R2 busy length after ignored start" : "R1 busy length", cyc, ecyc);
        chk(done_o == 1'b1, "R1 done after busy", int'(done_o), 1);
        chk(int'(res_lo_o) == el, inject ? "R2 lo word" : rq, int'(res_lo_o), el);
        chk(int'(res_hi_o) == eh, inject ? "R2 hi word" : rq, int'(res_hi_o), eh);
        chk(div_zero_o == edz, "R7 div_zero flag", int'(div_zero_o), int'(edz));
        @(negedge clk);
        chk(done_o == 1'b0 && !busy_o, "R8 done pulse one cycle", int'(done_o), 0);
        chk(int'(res_lo_o) == el && int'(res_hi_o) == eh, "R8 result hold",
            int'(res_lo_o), el);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy_o == 1'b0 && done_o == 1'b0, "R8 reset busy/done", int'(busy_o), 0);
        chk(res_hi_o == '0 && res_lo_o == '0, "R8 reset results", int'(res_lo_o), 0);
        chk(div_zero_o == 1'b0, "R8 reset div_zero", int'(div_zero_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R3 R4 R5 R6 R7: exhaustive sweep over all operand pairs and codes
        for (int op = 0; op < 4; op++) begin
            for (int a = 0; a <= MASK; a++) begin
                for (int b = 0; b <= MASK; b++) begin
                    run_op(2'(op), W'(a), W'(b), 1'b0);
                end
            end
        end
        // R6 corner: most negative over -1
        run_op(2'b11, W'(1 << (W-1)), W'(MASK), 1'b0);
        // R2: ignored starts in several modes
        run_op(2'b00, 4'd13, 4'd11, 1'b1);
        run_op(2'b01, 4'd9, 4'd6, 1'b1);
        run_op(2'b10, 4'd14, 4'd3, 1'b1);
        run_op(2'b11, 4'd10, 4'd3, 1'b1);
        run_op(2'b11, 4'd7, 4'd0, 1'b1);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule